// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Pool

This block holds up to three instructions that wait for one floating-point functional unit in a dynamically scheduled core. Each station keeps an opcode and two source operands. Each operand is either a finished value, marked by a tag of zero, or the nonzero 4-bit tag of the unit that will produce it. The three stations carry the fixed tags 10, 11 and 12. The station's tag is its name on the shared result bus and is the name that the rename logic records for the instruction's destination.

Each cycle, every waiting operand compares its tag with the result bus and copies the data on a match. A station whose two tags are both zero is ready. The lowest-tagged ready station goes to a two-stage execution stub, whose integer operations stand in for the real datapath. A finished result is offered on a bus request together with the station's tag. The result is held there until the arbiter grants it, and the grant frees the station.

Top module: `rs_pool`

## Requirements
- R1: After reset every station is free, `iss_ready` is 1, `iss_tag` is 10 and `req_valid` is 0.
- R2: An instruction is accepted on a rising edge where `iss_valid` and `iss_ready` are both 1. It goes to the lowest-numbered free station, and `iss_tag` shows that station's tag: station 0, 1 and 2 carry tags 10, 11 and 12.
- R3: An issued operand with tag 0 is taken as valid data. An operand with a nonzero tag waits, and its station does not execute until that tag is seen on the result bus.
- R4: In every cycle with `cdb_valid` high, each waiting operand whose tag equals `cdb_tag` copies `cdb_data` and clears its tag to 0. Operands whose tags do not match are left unchanged.
- R5: If an issuing operand's nonzero tag is on the result bus in the issue cycle, the operand takes the bus data at issue and is stored as ready.
- R6: Only a station with both operand tags at 0 is sent to execution, at most one per cycle. Among ready stations, the one with the lowest tag goes first.
- R7: An instruction issued with both operands ready raises `req_valid` three clock edges after the edge that accepted it: one edge to dispatch it, then two stages in the stub.
- R8: The result depends on the 2-bit opcode, with A the first operand and B the second: 0 gives A+B, 1 gives A−B, 2 gives A XOR B, 3 gives A. All arithmetic wraps at 32 bits.
- R9: While `req_valid` is 1 and `req_grant` is 0, `req_valid`, `req_tag` and `req_data` stay unchanged on the next cycle.
- R10: A grant given on an edge while `req_valid` is 1 frees the requesting station, and it can accept an issue in the next cycle. The next finished station, lowest tag first, is then offered.
- R11: When all three stations are busy, `iss_ready` is 0 in that same cycle, and an `iss_valid` pulse is ignored: no station is added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Opcode of the issued instruction |
| iss_a_tag | input | 4 | First operand producer tag, 0 = data valid |
| iss_a_data | input | 32 | First operand value |
| iss_b_tag | input | 4 | Second operand producer tag, 0 = data valid |
| iss_b_data | input | 32 | Second operand value |
| iss_ready | output | 1 | At least one station is free |
| iss_tag | output | 4 | Tag given to an instruction issued this cycle |
| cdb_valid | input | 1 | Result bus carries a value |
| cdb_tag | input | 4 | Producer tag on the result bus |
| cdb_data | input | 32 | Value on the result bus |
| req_valid | output | 1 | A finished result requests the bus |
| req_tag | output | 4 | Tag of the requesting station |
| req_data | output | 32 | Result offered for broadcast |
| req_grant | input | 1 | Arbiter accepts the offered result |

## Verification
The pool is driven with operands that are ready at issue, with operands that wait on an outside producer, and with an operand whose producer is broadcast in the issue cycle itself. Together these show whether readiness is decided by the tags or by the issue timing. Chains in which a later instruction waits on a station of the same pool show that the pool snoops its own granted results. A broadcast of a tag that nobody waits for shows that a mismatch captures nothing. A burst of three instructions waiting on one tag fills the pool, shows that a fourth issue is refused, and releases all three at once. This last pattern separates lowest-tag dispatch and a held request from other orderings, and it checks that a freed station can be reissued one cycle after its grant.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;

    localparam int TAG_W  = 4;
    localparam int DATA_W = 32;
    localparam int OP_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_XOR  = 2'd2,
        OP_PASS = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_FREE,
        ST_WAIT,
        ST_EXEC,
        ST_DONE
    } st_e;

    // An operand: tag 0 means data is valid, otherwise waiting on tag
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } opnd_t;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } bus_t;

    // Capture a broadcast value if this operand waits on it
    function automatic opnd_t snoop(opnd_t o, bus_t b);
        opnd_t r;
        r = o;
        if (b.valid && (o.tag != '0) && (o.tag == b.tag)) begin
            r.tag  = '0;
            r.data = b.data;
        end
        return r;
    endfunction

    function automatic logic both_ready(opnd_t a, opnd_t b);
        return (a.tag == '0) && (b.tag == '0);
    endfunction

    // Placeholder datapath
    function automatic logic [DATA_W-1:0] exec_op(op_e op, logic [DATA_W-1:0] a,
                                                  logic [DATA_W-1:0] b);
        logic [DATA_W-1:0] r;
        case (op)
            OP_ADD:  r = a + b;
            OP_SUB:  r = a - b;
            OP_XOR:  r = a ^ b;
            default: r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  oh
);
    // Lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        oh    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
                oh    = '0;
                oh[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pool_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  op_e               alloc_op,
    input  opnd_t             alloc_a,
    input  opnd_t             alloc_b,
    input  bus_t              cdb,
    input  logic              dispatch,
    input  logic              wb_valid,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              free_req,
    output st_e               state,
    output op_e               op,
    output opnd_t             src_a,
    output opnd_t             src_b,
    output logic [DATA_W-1:0] result,
    output logic              ready
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_FREE;
            op     <= OP_ADD;
            src_a  <= '0;
            src_b  <= '0;
            result <= '0;
        end else begin
            case (state)
                ST_FREE: begin
                    if (alloc) begin
                        state <= ST_WAIT;
                        op    <= alloc_op;
                        src_a <= alloc_a;
                        src_b <= alloc_b;
                    end
                end
                ST_WAIT: begin
                    src_a <= snoop(src_a, cdb);
                    src_b <= snoop(src_b, cdb);
                    if (dispatch) state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (wb_valid) begin
                        result <= wb_data;
                        state  <= ST_DONE;
                    end
                end
                default: begin
                    if (free_req) state <= ST_FREE;
                end
            endcase
        end
    end

    assign ready = (state == ST_WAIT) && both_ready(src_a, src_b);
endmodule

// File: rtl/rs_exec.sv
module rs_exec
    import rs_pool_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int LAT   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [IDX_W-1:0]  go_idx,
    input  op_e               go_op,
    input  logic [DATA_W-1:0] go_a,
    input  logic [DATA_W-1:0] go_b,
    output logic              wb_valid,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data
);
    logic [LAT-1:0]    stg_v;
    logic [IDX_W-1:0]  stg_idx [LAT];
    logic [DATA_W-1:0] stg_d   [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_v <= '0;
        end else begin
            stg_v[0] <= go;
            for (int k = 1; k < LAT; k++) stg_v[k] <= stg_v[k-1];
        end
    end

    always_ff @(posedge clk) begin
        stg_idx[0] <= go_idx;
        stg_d[0]   <= exec_op(go_op, go_a, go_b);
        for (int k = 1; k < LAT; k++) begin
            stg_idx[k] <= stg_idx[k-1];
            stg_d[k]   <= stg_d[k-1];
        end
    end

    assign wb_valid = stg_v[LAT-1];
    assign wb_idx   = stg_idx[LAT-1];
    assign wb_data  = stg_d[LAT-1];
endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pool_pkg::*;
#(
    parameter int NUM_RS   = 3,
    parameter int BASE_TAG = 10,
    parameter int EX_LAT   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [TAG_W-1:0]  iss_a_tag,
    input  logic [DATA_W-1:0] iss_a_data,
    input  logic [TAG_W-1:0]  iss_b_tag,
    input  logic [DATA_W-1:0] iss_b_data,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_data,
    output logic              req_valid,
    output logic [TAG_W-1:0]  req_tag,
    output logic [DATA_W-1:0] req_data,
    input  logic              req_grant
);
    localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;
    localparam logic [TAG_W-1:0] BASE_T = TAG_W'(BASE_TAG);

    bus_t  cdb;
    opnd_t in_a, in_b;
    logic  iss_fire;

    st_e               st_q    [NUM_RS];
    op_e               op_q    [NUM_RS];
    opnd_t             a_q     [NUM_RS];
    opnd_t             b_q     [NUM_RS];
    logic [DATA_W-1:0] res_q   [NUM_RS];

    logic [NUM_RS-1:0] free_vec, ready_vec, done_vec;
    logic [NUM_RS-1:0] free_oh, disp_oh, done_oh;
    logic              free_found, disp_found, done_found;
    logic [IDX_W-1:0]  free_idx, disp_idx, done_idx;

    logic              wb_valid;
    logic [IDX_W-1:0]  wb_idx;
    logic [DATA_W-1:0] wb_data;

    logic              lock_v;
    logic [IDX_W-1:0]  lock_idx;
    logic [IDX_W-1:0]  req_idx;

    // Result bus and issue operands, with same-cycle capture
    always_comb begin
        cdb.valid = cdb_valid;
        cdb.tag   = cdb_tag;
        cdb.data  = cdb_data;
        in_a.tag  = iss_a_tag;
        in_a.data = iss_a_data;
        in_b.tag  = iss_b_tag;
        in_b.data = iss_b_data;
        in_a      = snoop(in_a, cdb);
        in_b      = snoop(in_b, cdb);
    end

    assign iss_ready = free_found;
    assign iss_tag   = BASE_T + TAG_W'(free_idx);
    assign iss_fire  = iss_valid && free_found;

    genvar g;
    generate
        for (g = 0; g < NUM_RS; g++) begin : g_rs
            rs_entry u_entry (
                .clk      (clk),
                .rst      (rst),
                .alloc    (iss_fire && free_oh[g]),
                .alloc_op (op_e'(iss_op)),
                .alloc_a  (in_a),
                .alloc_b  (in_b),
                .cdb      (cdb),
                .dispatch (disp_oh[g]),
                .wb_valid (wb_valid && (wb_idx == IDX_W'(g))),
                .wb_data  (wb_data),
                .free_req (req_valid && req_grant && (req_idx == IDX_W'(g))),
                .state    (st_q[g]),
                .op       (op_q[g]),
                .src_a    (a_q[g]),
                .src_b    (b_q[g]),
                .result   (res_q[g]),
                .ready    (ready_vec[g])
            );
            assign free_vec[g] = (st_q[g] == ST_FREE);
            assign done_vec[g] = (st_q[g] == ST_DONE);
        end
    endgenerate

    rs_pick #(.N(NUM_RS), .IW(IDX_W)) u_free_pick (
        .req(free_vec), .found(free_found), .idx(free_idx), .oh(free_oh)
    );

    rs_pick #(.N(NUM_RS), .IW(IDX_W)) u_disp_pick (
        .req(ready_vec), .found(disp_found), .idx(disp_idx), .oh(disp_oh)
    );

    rs_pick #(.N(NUM_RS), .IW(IDX_W)) u_done_pick (
        .req(done_vec), .found(done_found), .idx(done_idx), .oh(done_oh)
    );

    rs_exec #(.IDX_W(IDX_W), .LAT(EX_LAT)) u_exec (
        .clk      (clk),
        .rst      (rst),
        .go       (disp_found),
        .go_idx   (disp_idx),
        .go_op    (op_q[disp_idx]),
        .go_a     (a_q[disp_idx].data),
        .go_b     (b_q[disp_idx].data),
        .wb_valid (wb_valid),
        .wb_idx   (wb_idx),
        .wb_data  (wb_data)
    );

    // Keep the offered result fixed until the arbiter takes it
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_v   <= 1'b0;
            lock_idx <= '0;
        end else if (req_valid && !req_grant) begin
            lock_v   <= 1'b1;
            lock_idx <= req_idx;
        end else begin
            lock_v   <= 1'b0;
        end
    end

    assign req_idx   = lock_v ? lock_idx : done_idx;
    assign req_valid = lock_v || done_found;
    assign req_tag   = BASE_T + TAG_W'(req_idx);
    assign req_data  = res_q[req_idx];

    logic unused_done;
    assign unused_done = ^done_oh;
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
    parameter int NUM_RS   = 3,
    parameter int BASE_TAG = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic              req_valid,
    input logic [3:0]        req_tag,
    input logic [31:0]       req_data,
    input logic              req_grant,
    input logic [NUM_RS-1:0] disp_oh,
    input logic [NUM_RS-1:0] ready_vec,
    input logic [NUM_RS-1:0] free_vec
);
    // R9: offered result held until granted
    a_r9_hold_until_grant: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_grant |=> req_valid && $stable(req_tag) && $stable(req_data));

    // R2: requests carry one of the pool's own tags
    a_r2_own_tag: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_tag >= 4'(BASE_TAG)) && (req_tag < 4'(BASE_TAG + NUM_RS)));

    // R6: at most one dispatch, only of a ready station
    a_r6_single_ready_dispatch: assert property (@(posedge clk) disable iff (rst)
        $onehot0(disp_oh) && ((disp_oh & ~ready_vec) == '0));

    // R6: no lower-tagged station is ready when one is dispatched
    a_r6_lowest_first: assert property (@(posedge clk) disable iff (rst)
        (disp_oh != '0) |-> (((disp_oh - NUM_RS'(1)) & ready_vec) == '0));

    // R10: grant makes a station available next cycle
    a_r10_free_next: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_grant |=> iss_ready);

    // R11: filling the last free station blocks issue next cycle
    a_r11_full_stall: assert property (@(posedge clk) disable iff (rst)
        iss_valid && iss_ready && ($countones(free_vec) == 1) && !(req_valid && req_grant)
        |=> !iss_ready);
endmodule

bind rs_pool rs_pool_chk #(.NUM_RS(NUM_RS), .BASE_TAG(BASE_TAG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_ready (iss_ready),
    .req_valid (req_valid),
    .req_tag   (req_tag),
    .req_data  (req_data),
    .req_grant (req_grant),
    .disp_oh   (disp_oh),
    .ready_vec (ready_vec),
    .free_vec  (free_vec)
);

// File: tb/rs_pool_test.sv
module rs_pool_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic [1:0]  iss_op = 2'd0;
    logic [3:0]  iss_a_tag = 4'd0, iss_b_tag = 4'd0;
    logic [31:0] iss_a_data = 32'd0, iss_b_data = 32'd0;
    logic        iss_ready;
    logic [3:0]  iss_tag;
    logic        cdb_valid;
    logic [3:0]  cdb_tag;
    logic [31:0] cdb_data;
    logic        req_valid;
    logic [3:0]  req_tag;
    logic [31:0] req_data;
    logic        grant = 1'b0;

    logic        ext_v = 1'b0, fwd_v = 1'b0, gnt_en = 1'b0;
    logic [3:0]  ext_tag = 4'd0, fwd_tag = 4'd0;
    logic [31:0] ext_data = 32'd0, fwd_data = 32'd0;

    int nchk = 0;
    int nbad = 0;

    typedef struct { logic [3:0] tag; logic [31:0] data; } item_t;
    item_t       exp_q[$];
    logic [31:0] tagval [16];

    always #10 clk = ~clk;

    assign cdb_valid = fwd_v | ext_v;
    assign cdb_tag   = fwd_v ? fwd_tag : ext_tag;
    assign cdb_data  = fwd_v ? fwd_data : ext_data;

    rs_pool uut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_a_tag(iss_a_tag), .iss_a_data(iss_a_data),
        .iss_b_tag(iss_b_tag), .iss_b_data(iss_b_data),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .req_valid(req_valid), .req_tag(req_tag), .req_data(req_data),
        .req_grant(grant)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Opcode meaning taken from R8
    function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        case (op)
            2'd0:    return a + b;
            2'd1:    return a - b;
            2'd2:    return a ^ b;
            default: return a;
        endcase
    endfunction

    // Monitor: grants requests, forwards them on the bus, compares with expectations
    always @(negedge clk) begin
        if (grant) begin
            grant = 1'b0;
            fwd_v = 1'b0;
        end else if (!rst && gnt_en && req_valid) begin
            int hit;
            grant    = 1'b1;
            fwd_v    = 1'b1;
            fwd_tag  = req_tag;
            fwd_data = req_data;
            hit = -1;
            foreach (exp_q[i]) if (hit < 0 && exp_q[i].tag == req_tag) hit = i;
            if (hit < 0) begin
                chk(1'b0, "R8 unexpected result tag", {28'd0, req_tag}, 32'd0);
            end else begin
                chk(req_data == exp_q[hit].data, "R8 result value", req_data, exp_q[hit].data);
                exp_q.delete(hit);
            end
        end
    end

    // Driver: called just after a falling edge, returns just after the next one
    task automatic issue(input logic [1:0] op, input logic [3:0] ta, input logic [31:0] da,
                         input logic [3:0] tb, input logic [31:0] db,
                         output logic acc, output logic [3:0] tg);
        item_t it;
        iss_valid = 1'b1; iss_op = op;
        iss_a_tag = ta; iss_a_data = da; iss_b_tag = tb; iss_b_data = db;
        #1;
        acc = iss_ready;
        tg  = iss_tag;
        @(negedge clk);
        iss_valid = 1'b0;
        if (acc) begin
            it.tag  = tg;
            it.data = model(op, (ta == 4'd0) ? da : tagval[ta], (tb == 4'd0) ? db : tagval[tb]);
            tagval[tg] = it.data;
            exp_q.push_back(it);
        end
    endtask

    task automatic drain(input string what);
        for (int n = 0; n < 200 && exp_q.size() != 0; n++) @(negedge clk);
        chk(exp_q.size() == 0, what, exp_q.size(), 0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        nchk++;
        nbad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic       acc;
        logic [3:0] tg, t_a, t_b;
        int         n;
        logic [31:0] held;

        for (int t = 0; t < 16; t++) tagval[t] = 32'h100 * t + 32'd7;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(iss_ready == 1'b1, "R1 iss_ready after reset", iss_ready, 1);
        chk(iss_tag == 4'd10, "R1 iss_tag after reset", iss_tag, 10);
        chk(req_valid == 1'b0, "R1 req_valid after reset", req_valid, 0);
        @(negedge clk);

        // R7 latency with ready operands, R2 first tag
        issue(2'd0, 4'd0, 32'd5, 4'd0, 32'd3, acc, tg);
        chk(acc == 1'b1, "R2 issue accepted", acc, 1);
        chk(tg == 4'd10, "R2 first station tag", tg, 10);
        n = 0;
        while (!req_valid && n < 10) begin @(negedge clk); n++; end
        chk(n == 3, "R7 edges from issue to request", n, 3);
        #2 gnt_en = 1'b1;
        drain("R7 result delivered");

        // R8 opcode variety
        @(negedge clk);
        issue(2'd1, 4'd0, 32'd20, 4'd0, 32'd27, acc, tg);
        issue(2'd2, 4'd0, 32'hF0F0, 4'd0, 32'h0FF0, acc, tg);
        issue(2'd3, 4'd0, 32'd99, 4'd0, 32'd1, acc, tg);
        drain("R8 opcode results delivered");

        // R3 waiting operand, R4 mismatch ignored then match captured
        @(negedge clk);
        issue(2'd0, 4'd4, 32'd0, 4'd0, 32'd2, acc, tg);
        ext_v = 1'b1; ext_tag = 4'd7; ext_data = 32'd1234;
        @(negedge clk);
        ext_v = 1'b0;
        repeat (5) @(negedge clk);
        chk(req_valid == 1'b0, "R3 R4 waiting station stays idle", req_valid, 0);
        ext_v = 1'b1; ext_tag = 4'd4; ext_data = tagval[4];
        @(negedge clk);
        ext_v = 1'b0;
        drain("R4 captured operand result");

        // R5 producer broadcast in the issue cycle
        @(negedge clk);
        ext_v = 1'b1; ext_tag = 4'd5; ext_data = tagval[5];
        issue(2'd0, 4'd5, 32'd0, 4'd0, 32'd1, acc, tg);
        ext_v = 1'b0;
        drain("R5 same-cycle capture result");

        // R4 chain through the pool's own results
        @(negedge clk);
        issue(2'd0, 4'd0, 32'd1, 4'd0, 32'd2, acc, t_a);
        issue(2'd1, t_a, 32'd0, 4'd0, 32'd1, acc, t_b);
        issue(2'd0, t_b, 32'd0, t_a, 32'd0, acc, tg);
        drain("R4 chained results");

        // R11 full pool, R6 dispatch order, R9 hold, R10 reuse
        @(negedge clk);
        #2 gnt_en = 1'b0;
        @(negedge clk);
        issue(2'd0, 4'd6, 32'd0, 4'd0, 32'd10, acc, tg);
        chk(tg == 4'd10, "R2 burst tag 10", tg, 10);
        issue(2'd0, 4'd6, 32'd0, 4'd0, 32'd20, acc, tg);
        chk(tg == 4'd11, "R2 burst tag 11", tg, 11);
        issue(2'd0, 4'd6, 32'd0, 4'd0, 32'd30, acc, tg);
        chk(tg == 4'd12, "R2 burst tag 12", tg, 12);
        chk(iss_ready == 1'b0, "R11 full pool refuses issue", iss_ready, 0);
        issue(2'd0, 4'd0, 32'd1, 4'd0, 32'd1, acc, tg);
        chk(acc == 1'b0, "R11 fourth issue ignored", acc, 0);
        ext_v = 1'b1; ext_tag = 4'd6; ext_data = tagval[6];
        @(negedge clk);
        ext_v = 1'b0;
        n = 0;
        while (!req_valid && n < 10) begin @(negedge clk); n++; end
        chk(req_tag == 4'd10, "R6 lowest tag finishes first", req_tag, 10);
        held = req_data;
        repeat (3) @(negedge clk);
        chk(req_valid == 1'b1, "R9 request held", req_valid, 1);
        chk(req_tag == 4'd10, "R9 tag held", req_tag, 10);
        chk(req_data == held, "R9 data held", req_data, held);
        chk(iss_ready == 1'b0, "R11 still full before grant", iss_ready, 0);
        @(posedge clk);
        #2 gnt_en = 1'b1;
        @(posedge clk);
        #2 gnt_en = 1'b0;
        @(negedge clk);
        chk(iss_ready == 1'b1, "R10 freed station ready next cycle", iss_ready, 1);
        chk(iss_tag == 4'd10, "R10 freed station tag", iss_tag, 10);
        chk(req_tag == 4'd11, "R10 next request lowest tag", req_tag, 11);
        issue(2'd0, 4'd0, 32'd40, 4'd0, 32'd2, acc, tg);
        chk(acc == 1'b1, "R10 reissue accepted", acc, 1);
        #2 gnt_en = 1'b1;
        drain("R10 remaining results delivered");

        repeat (4) @(negedge clk);
        chk(req_valid == 1'b0, "R10 pool empty at end", req_valid, 0);
        finish_run();
    end

endmodule